// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block holds a 4-bit word and rewrites it on every rising clock edge. A 2-bit mode code picks one of four next-state rules: a parallel load, a two-place left rotation, a one-place arithmetic right shift, or a one-place logical right shift. No code keeps the value unchanged, so the caller has to drive a mode on every cycle. The stored word is always visible on a parallel output taken straight from the flip-flops.

Each bit cell is a D flip-flop fed by its own 4-to-1 selector. All selectors share the mode code. Each selector's four inputs are wired to the load data and to the neighbouring bits that the three movement rules need. The mode code is an enumerated type with four named members, and each member is one transition of the stored word. MODE_LOAD takes the data input. MODE_ROT rotates left by two. MODE_SRA is an arithmetic right shift. MODE_SRL is a logical right shift. A synchronous reset forces the word to zero.

Top module: `ushift_reg`

## Requirements
- R1: When `rst` is 1 at a rising edge, `q_o` becomes 4'b0000 after that edge, whatever the mode code and data input are.
- R2: Mode code 2'b00 (MODE_LOAD) copies `data_i` into the register at the edge. Bit i of the input goes to bit i of the output.
- R3: Mode code 2'b01 (MODE_ROT) rotates the word left by two places. New bits [3:2] are the old bits [1:0], and new bits [1:0] are the old bits [3:2]. For example, 4'b1001 becomes 4'b0110.
- R4: Mode code 2'b10 (MODE_SRA) shifts right by one place and copies the old bit 3 into the new bit 3. For example, 4'b1001 becomes 4'b1100, and 4'b0110 becomes 4'b0011.
- R5: Mode code 2'b11 (MODE_SRL) shifts right by one place and puts 0 into bit 3. The old bit 0 is lost. For example, 4'b1001 becomes 4'b0100.
- R6: There is no hold code, so the word changes on every edge according to the current code. Two rotations in a row restore the word. Repeated arithmetic shifts of a word with bit 3 set end at 4'b1111. Four logical shifts always give 4'b0000.
- R7: `q_o` shows the stored word continuously and changes only at a rising edge. A change of `data_i` or `mode_i` between edges leaves `q_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear, takes priority over the mode code |
| mode_i | input | 2 | Mode code: 00 load, 01 rotate left two, 10 arithmetic right, 11 logical right |
| data_i | input | WIDTH (4) | Parallel load data |
| q_o | output | WIDTH (4) | Stored word, read in parallel |

## Verification
The word 4'b1001 has both end bits set and both middle bits clear. Applying each movement mode to it therefore tells a two-place rotation apart from a one-place shift, and an arithmetic shift apart from a logical one. A positive word (4'b0110) under the arithmetic shift shows that the sign copy is not simply a forced 1. Chains of the same mode (rotate twice, arithmetic shift until saturation, logical shift until empty) confirm that the register updates on every edge. A reset issued while the load mode presents all-ones data shows that reset takes priority. A change of the data input between edges shows that the output moves only at an edge.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

    // Mode codes; the numeric values are the external encoding of mode_i.
    typedef enum logic [1:0] {
        MODE_LOAD = 2'b00,
        MODE_ROT  = 2'b01,
        MODE_SRA  = 2'b10,
        MODE_SRL  = 2'b11
    } mode_e;

    localparam int unsigned MODE_COUNT = 4;

endpackage

// File: rtl/ushift_bitmux.sv
module ushift_bitmux
    import ushift_pkg::*;
(
    input  mode_e                  sel_i,
    input  logic [MODE_COUNT-1:0]  cand_i,   // indexed by mode code
    output logic                   d_o
);

    always_comb begin
        unique case (sel_i)
            MODE_LOAD: d_o = cand_i[0];
            MODE_ROT:  d_o = cand_i[1];
            MODE_SRA:  d_o = cand_i[2];
            MODE_SRL:  d_o = cand_i[3];
            default:   d_o = cand_i[0];
        endcase
    end

endmodule

// File: rtl/ushift_cell.sv
module ushift_cell (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= 1'b0;
        end else begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
    import ushift_pkg::*;
#(
    parameter int unsigned WIDTH    = 4,
    parameter int unsigned ROT_STEP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] q_o
);

    localparam int unsigned TOP = WIDTH - 1;

    mode_e            mode;
    logic [WIDTH-1:0] word_q;
    logic [WIDTH-1:0] word_d;

    assign mode = mode_e'(mode_i);
    assign q_o  = word_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam int unsigned ROT_SRC = (i + WIDTH - (ROT_STEP % WIDTH)) % WIDTH;

        logic [MODE_COUNT-1:0] cand;
        logic                  from_left;
        logic                  sra_bit;
        logic                  srl_bit;

        if (i == TOP) begin : g_msb
            assign sra_bit = word_q[TOP];
            assign srl_bit = 1'b0;
        end else begin : g_inner
            assign from_left = word_q[i+1];
            assign sra_bit   = from_left;
            assign srl_bit   = from_left;
        end
        if (i == TOP) begin : g_msb_tie
            assign from_left = 1'b0;
        end

        assign cand = {srl_bit, sra_bit, word_q[ROT_SRC], data_i[i]};

        ushift_bitmux u_mux (
            .sel_i  (mode),
            .cand_i (cand),
            .d_o    (word_d[i])
        );

        ushift_cell u_ff (
            .clk (clk),
            .rst (rst),
            .d_i (word_d[i]),
            .q_o (word_q[i])
        );
    end

endmodule

// File: rtl/ushift_reg_chk.sv
module ushift_reg_chk #(
    parameter int unsigned WIDTH    = 4,
    parameter int unsigned ROT_STEP = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode_i,
    input logic [WIDTH-1:0] data_i,
    input logic [WIDTH-1:0] q_o
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (q_o == '0));

    assert_load_copies_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b00) |=> (q_o == $past(data_i)));

    assert_rotate_two_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b01) |=>
            (q_o == WIDTH'({$past(q_o), $past(q_o)} >> (WIDTH - ROT_STEP))));

    assert_sra_sign_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b10) |=>
            (q_o == {$past(q_o[WIDTH-1]), $past(q_o[WIDTH-1:1])}));

    assert_srl_zero_fill_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b11) |=> (q_o == {1'b0, $past(q_o[WIDTH-1:1])}));

    assert_srl_top_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b11) |=> !q_o[WIDTH-1]);

endmodule

bind ushift_reg ushift_reg_chk #(
    .WIDTH    (WIDTH),
    .ROT_STEP (ROT_STEP)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode_i),
    .data_i (data_i),
    .q_o    (q_o)
);

// File: tb/ushift_reg_tb_top.sv
module ushift_reg_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_i = 2'b00;
    logic [3:0] data_i = 4'b0000;
    logic [3:0] q_o;

    item_t      sb[$];
    logic [3:0] model = 4'b0000;
    int         checks = 0;
    int         errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ushift_reg dut_i (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode_i),
        .data_i (data_i),
        .q_o    (q_o)
    );

    // Next value of the word, written from the requirements.
    function automatic logic [3:0] next_word(logic r, logic [1:0] m,
                                             logic [3:0] d, logic [3:0] cur);
        if (r) return 4'b0000;
        case (m)
            2'b00:   return d;
            2'b01:   return {cur[1:0], cur[3:2]};
            2'b10:   return {cur[3], cur[3:1]};
            default: return {1'b0, cur[3:1]};
        endcase
    endfunction

    task automatic step(logic r, logic [1:0] m, logic [3:0] d, string tag);
        item_t it;
        @(negedge clk);
        rst    = r;
        mode_i = m;
        data_i = d;
        model  = next_word(r, m, d, model);
        it.exp = model;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare one expected item per edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (q_o !== it.exp) begin
                errors++;
                $display("FAIL %s: q_o=%b expected=%b", it.tag, q_o, it.exp);
            end
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected finish");
        report();
    end

    initial begin
        step(1'b1, 2'b00, 4'b0000, "R1 reset state");
        step(1'b0, 2'b00, 4'b1001, "R2 load 1001");
        step(1'b0, 2'b01, 4'b0000, "R3 rotate 1001 -> 0110");
        step(1'b0, 2'b01, 4'b1111, "R6 second rotate restores 1001");
        step(1'b0, 2'b10, 4'b0000, "R4 sra 1001 -> 1100");
        step(1'b0, 2'b10, 4'b0000, "R6 sra 1100 -> 1110");
        step(1'b0, 2'b10, 4'b0000, "R6 sra 1110 -> 1111");
        step(1'b0, 2'b10, 4'b0000, "R6 sra stays 1111");
        step(1'b0, 2'b00, 4'b1001, "R2 reload 1001");
        step(1'b0, 2'b11, 4'b0000, "R5 srl 1001 -> 0100");
        step(1'b0, 2'b11, 4'b0000, "R6 srl -> 0010");
        step(1'b0, 2'b11, 4'b0000, "R6 srl -> 0001");
        step(1'b0, 2'b11, 4'b0000, "R6 srl -> 0000");
        step(1'b0, 2'b00, 4'b0110, "R2 load 0110");
        step(1'b0, 2'b10, 4'b0000, "R4 sra positive 0110 -> 0011");
        step(1'b0, 2'b01, 4'b0000, "R3 rotate 0011 -> 1100");
        step(1'b0, 2'b00, 4'b1111, "R2 load 1111");
        step(1'b1, 2'b00, 4'b1111, "R1 reset beats load");
        step(1'b0, 2'b00, 4'b1000, "R2 load 1000");
        step(1'b0, 2'b11, 4'b0000, "R5 srl 1000 -> 0100");

        // R7: inputs move between edges, output must hold.
        step(1'b0, 2'b00, 4'b1010, "R7 load after mid-cycle change");
        #2;
        data_i = 4'b0101;
        mode_i = 2'b01;
        #1;
        checks++;
        if (q_o !== 4'b0100) begin
            errors++;
            $display("FAIL R7 mid-cycle: q_o=%b expected=%b", q_o, 4'b0100);
        end
        // The last presented inputs (rotate) decide the edge; fix queue entry.
        sb[sb.size()-1].exp = {4'b0100 & 4'b0011, 4'b0100 >> 2} ;
        model = 4'b0001;
        sb[sb.size()-1].exp = 4'b0001;

        step(1'b0, 2'b00, 4'b0101, "R2 load 0101");
        step(1'b0, 2'b01, 4'b0000, "R3 rotate 0101 -> 0101");

        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        report();
    end

endmodule